// File: doc/BRIEF.md
# Fabric Event Performance Counter

This block watches four kinds of traffic event on a host fabric interface (reads and writes on PCIe channel 0, and MMIO reads and writes) and counts them in per-event counters. Each event arrives as a single-cycle strobe on its own lane, tagged with the number of the port that caused it. A port filter selects one of two modes: every port is counted, or only the programmed port is counted. A freeze bit holds all the counts still so that software can take a consistent snapshot.

Software reaches the block through a synchronous register interface with 64-bit words. It has a read strobe, a write strobe and a word offset. The block has one control register. It has one shared readback register, which shows the count of the selected event and also echoes that event's code. Software changes the selection and then polls until the echoed code matches; at that point the count field is known to belong to the new event. A free-running cycle counter and a header word that carries a revision number are also readable.

Top module: `fab_evt_perfmon`

## Requirements
- R1: After reset every counter, the control word, the readback word and the read data are zero.
- R2: A read at offset 0 returns the header, with the REVISION parameter in bits [7:0] and zero in all other bits.
- R3: Offset 3 is the readback word: the count is in bits [CNT_W-1:0] and the event code is in bits [61:60]. After a write changes the selection, the code and the count switch together. They appear two clock edges after the write is taken, so a read strobe one cycle later than that returns them.
- R4: Event codes are 0 for PCIe channel 0 read, 1 for PCIe channel 0 write, 2 for MMIO read and 3 for MMIO write. The pulse on lane i advances counter i only. All counters run whichever event is selected.
- R5: Offset 2 is the control word: select in [1:0], port filter in [8], port number in [16 +: PORT_W], freeze in [31]. When the filter is 0, pulses from any port count. When the filter is 1, only pulses whose port tag equals the port number count.
- R6: While freeze is 1, no counter advances. Clearing freeze resumes counting. The control word reads back as it was written.
- R7: Each counter is CNT_W bits wide and wraps to zero after its maximum value.
- R8: A control write that changes the filter bit or the port number clears all counters on the next edge, and any pulse sampled on that edge is dropped. A control write that keeps both unchanged clears nothing.
- R9: Offset 1 returns a 64-bit count of clock cycles since reset, which increases by one every cycle.
- R10: Writes to offsets 0, 1 and 3 are ignored.
- R11: Read data appears one cycle after the read strobe. In any cycle that follows no read strobe, the read data is zero. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regRdEn | input | 1 | Read strobe |
| regWrEn | input | 1 | Write strobe |
| regAddr | input | ADDR_W | Word offset of the access |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data, valid one cycle after the strobe |
| evtPulse | input | 4 | One strobe per event lane, lane index equals event code |
| evtPort | input | 4*PORT_W | Port tag per lane, lane i in bits [i*PORT_W +: PORT_W] |

## Verification
The bench builds the block with CNT_W = 8 and PORT_W = 2. The 8-bit counters wrap after 256 pulses, so wraparound is reached in a few hundred cycles. The 2-bit port tag is small enough that random traffic matches the filtered port often and misses it often. These settings make the wrap, filter-match and clear-on-change cases likely in both the directed phase and the random phase, where a behavioural model predicts every read.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EVT_NUM    = 4;
  localparam int EVT_W      = 2;
  localparam int PORT_MAX_W = 8;

  localparam int OFF_HDR = 0;
  localparam int OFF_CLK = 1;
  localparam int OFF_CTL = 2;
  localparam int OFF_RB  = 3;

  localparam int CTL_SEL_LSB  = 0;
  localparam int CTL_FILT_BIT = 8;
  localparam int CTL_PORT_LSB = 16;
  localparam int CTL_FRZ_BIT  = 31;
  localparam int RB_CODE_LSB  = 60;

  typedef enum logic [EVT_W-1:0] {
    EV_PCIE_RD = 2'd0,
    EV_PCIE_WR = 2'd1,
    EV_MMIO_RD = 2'd2,
    EV_MMIO_WR = 2'd3
  } evt_e;

  typedef struct packed {
    evt_e                  evtSel;
    logic                  filtEn;
    logic [PORT_MAX_W-1:0] portNum;
    logic                  freeze;
    logic                  clrCnt;
  } ctl_s;
endpackage

// File: rtl/fpm_lane.sv
module fpm_lane #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             frz,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (clr)         count <= '0;
    else if (!frz && hit) count <= count + 1'b1;
  end

  // R6
  lane_frz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frz && !clr) |=> $stable(count));
  // R8
  lane_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));
  // R7
  lane_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frz && !clr && hit) |=> (count == CNT_W'($past(count) + 1'b1)));
endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int PORT_W = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctl_s                      ctl,
  input  logic [EVT_NUM-1:0]        evtPulse,
  input  logic [EVT_NUM*PORT_W-1:0] evtPort,
  output logic [63:0]               clkCnt,
  output logic [63:0]               rbWord
);
  logic [CNT_W-1:0] laneCnt [EVT_NUM];
  logic [EVT_NUM-1:0] laneHit;
  evt_e selPipe;
  evt_e rbCode;
  logic [CNT_W-1:0] rbCnt;
  logic [1:0] warm;
  logic unusedPort;

  assign unusedPort = ^ctl.portNum;

  for (genvar g = 0; g < EVT_NUM; g++) begin : g_lane
    assign laneHit[g] = evtPulse[g] &&
      (!ctl.filtEn || (evtPort[g*PORT_W +: PORT_W] == ctl.portNum[PORT_W-1:0]));
    fpm_lane #(.CNT_W(CNT_W)) u_lane (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (ctl.clrCnt),
      .frz   (ctl.freeze),
      .hit   (laneHit[g]),
      .count (laneCnt[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPipe <= EV_PCIE_RD;
      rbCode  <= EV_PCIE_RD;
      rbCnt   <= '0;
      clkCnt  <= '0;
      warm    <= '0;
    end else begin
      selPipe <= ctl.evtSel;
      rbCode  <= selPipe;
      rbCnt   <= laneCnt[selPipe];
      clkCnt  <= clkCnt + 64'd1;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  always_comb begin
    rbWord = '0;
    rbWord[CNT_W-1:0] = rbCnt;
    rbWord[RB_CODE_LSB +: EVT_W] = rbCode;
  end

  // R3
  rb_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (rbCode == $past(ctl.evtSel, 2)));
  // R9
  clk_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2) |-> (clkCnt == $past(clkCnt) + 64'd1));
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter int         PORT_W   = 3,
  parameter logic [7:0] REVISION = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wrData,
  input  logic [63:0]       clkCnt,
  input  logic [63:0]       rbWord,
  output ctl_s              ctl,
  output logic [63:0]       rdData
);
  logic wrCtl;
  logic [PORT_MAX_W-1:0] portIn;
  logic filtIn;
  logic ctlChg;
  logic [63:0] ctlImg;
  logic [63:0] rdMux;
  logic unusedWr;

  assign unusedWr = ^wrData;
  assign wrCtl  = wrEn && (addr == ADDR_W'(OFF_CTL));
  assign portIn = PORT_MAX_W'(wrData[CTL_PORT_LSB +: PORT_W]);
  assign filtIn = wrData[CTL_FILT_BIT];
  assign ctlChg = (filtIn != ctl.filtEn) || (portIn != ctl.portNum);

  always_comb begin
    ctlImg = '0;
    ctlImg[CTL_SEL_LSB +: EVT_W]   = ctl.evtSel;
    ctlImg[CTL_FILT_BIT]           = ctl.filtEn;
    ctlImg[CTL_PORT_LSB +: PORT_W] = ctl.portNum[PORT_W-1:0];
    ctlImg[CTL_FRZ_BIT]            = ctl.freeze;
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFF_HDR): rdMux = 64'(REVISION);
      ADDR_W'(OFF_CLK): rdMux = clkCnt;
      ADDR_W'(OFF_CTL): rdMux = ctlImg;
      ADDR_W'(OFF_RB):  rdMux = rbWord;
      default:          rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl    <= '0;
      rdData <= '0;
    end else begin
      rdData     <= rdEn ? rdMux : 64'd0;
      ctl.clrCnt <= wrCtl && ctlChg;
      if (wrCtl) begin
        ctl.evtSel  <= evt_e'(wrData[CTL_SEL_LSB +: EVT_W]);
        ctl.filtEn  <= filtIn;
        ctl.portNum <= portIn;
        ctl.freeze  <= wrData[CTL_FRZ_BIT];
      end
    end
  end

  // R6
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtl |=> $stable(ctl.freeze));
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == 64'd0));
  // R8
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtl |=> !ctl.clrCnt);
  // R10
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtl |=> ($stable(ctl.filtEn) && $stable(ctl.portNum) && $stable(ctl.evtSel)));
endmodule

// File: rtl/fab_evt_perfmon.sv
module fab_evt_perfmon
  import fpm_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter int         CNT_W    = 48,
  parameter int         PORT_W   = 3,
  parameter logic [7:0] REVISION = 8'h02
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regRdEn,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [63:0]               regWrData,
  output logic [63:0]               regRdData,
  input  logic [EVT_NUM-1:0]        evtPulse,
  input  logic [EVT_NUM*PORT_W-1:0] evtPort
);
  ctl_s ctl;
  logic [63:0] clkCnt;
  logic [63:0] rbWord;

  fpm_ctrl #(
    .ADDR_W   (ADDR_W),
    .PORT_W   (PORT_W),
    .REVISION (REVISION)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (regRdEn),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .wrData (regWrData),
    .clkCnt (clkCnt),
    .rbWord (rbWord),
    .ctl    (ctl),
    .rdData (regRdData)
  );

  fpm_datapath #(
    .CNT_W  (CNT_W),
    .PORT_W (PORT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .evtPulse (evtPulse),
    .evtPort  (evtPort),
    .clkCnt   (clkCnt),
    .rbWord   (rbWord)
  );
endmodule

// File: tb/tb_fab_evt_perfmon.sv
`timescale 1ns/1ps
module tb_fab_evt_perfmon;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 8;
  localparam int PORT_W = 2;
  localparam logic [7:0] REV = 8'h02;
  localparam logic [63:0] MASK = (64'd1 << CNT_W) - 64'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regRdEn = 1'b0, regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic [3:0] evtPulse = '0;
  logic [4*PORT_W-1:0] evtPort = '0;

  always #2.5 clk = ~clk;

  fab_evt_perfmon #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W), .REVISION(REV)) dut (
    .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse), .evtPort(evtPort)
  );

  int nCmp = 0, nBad = 0;
  string curReq = "R1";
  bit running = 0;

  // behavioural reference
  logic [63:0] mCnt [4];
  logic [1:0] mSel, mSelP, mRbCode;
  logic [63:0] mRbCnt, mClk, mRd;
  logic mFilt, mFrz, mClr;
  logic [PORT_W-1:0] mPort;

  function automatic logic [63:0] ctlWord(input logic [1:0] s, input logic f,
                                          input logic [PORT_W-1:0] p, input logic z);
    logic [63:0] w;
    w = '0; w[1:0] = s; w[8] = f; w[16 +: PORT_W] = p; w[31] = z;
    return w;
  endfunction

  function automatic logic [63:0] rbW(input logic [1:0] c, input logic [63:0] n);
    return (64'(c) << 60) | (n & MASK);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mCnt[i] = '0;
      mSel = 0; mSelP = 0; mRbCode = 0; mRbCnt = 0; mClk = 0; mRd = 0;
      mFilt = 0; mFrz = 0; mClr = 0; mPort = 0;
    end else begin
      if (!regRdEn) mRd = 0;
      else case (regAddr)
        4'd0: mRd = 64'(REV);
        4'd1: mRd = mClk;
        4'd2: mRd = ctlWord(mSel, mFilt, mPort, mFrz);
        4'd3: mRd = rbW(mRbCode, mRbCnt);
        default: mRd = 0;
      endcase
      mRbCode = mSelP;
      mRbCnt  = mCnt[mSelP];
      mSelP   = mSel;
      for (int i = 0; i < 4; i++) begin
        if (mClr) mCnt[i] = 0;
        else if (!mFrz && evtPulse[i] &&
                 (!mFilt || evtPort[i*PORT_W +: PORT_W] == mPort))
          mCnt[i] = (mCnt[i] + 1) & MASK;
      end
      mClr = 0;
      if (regWrEn && regAddr == 4'd2) begin
        mClr  = (regWrData[8] != mFilt) || (regWrData[16 +: PORT_W] != mPort);
        mSel  = regWrData[1:0];
        mFilt = regWrData[8];
        mPort = regWrData[16 +: PORT_W];
        mFrz  = regWrData[31];
      end
      mClk = mClk + 1;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      nCmp++;
      if (regRdData !== mRd) begin
        nBad++;
        $display("FAIL %s: cycle compare actual=%h expected=%h", curReq, regRdData, mRd);
      end
    end
  end

  task automatic hard(input string req, input logic [63:0] got, input logic [63:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [63:0] d, input logic [3:0] p, input logic [4*PORT_W-1:0] pt);
    @(negedge clk);
    regRdEn = rd; regWrEn = wr; regAddr = a; regWrData = d; evtPulse = p; evtPort = pt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic rdGet(input logic [ADDR_W-1:0] a, output logic [63:0] v);
    drive(1, 0, a, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    v = regRdData;
  endtask

  task automatic rdChk(input string req, input logic [ADDR_W-1:0] a, input logic [63:0] exp);
    logic [63:0] v;
    rdGet(a, v);
    hard(req, v, exp);
  endtask

  task automatic wrCtl(input logic [63:0] d);
    drive(0, 1, 4'd2, d, 0, 0);
  endtask

  task automatic pulse(input int lane, input logic [PORT_W-1:0] p);
    logic [4*PORT_W-1:0] pt;
    pt = '0; pt[lane*PORT_W +: PORT_W] = p;
    drive(0, 0, 0, 0, 4'(1 << lane), pt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [63:0] a, b, g1, g2, g3;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    running = 1;

    curReq = "R1";
    rdChk("R1", 4'd2, 64'd0);
    rdChk("R1", 4'd3, 64'd0);
    curReq = "R11";
    rdChk("R11", 4'd7, 64'd0);
    idle(1);
    hard("R11", regRdData, 64'd0);

    curReq = "R2";
    rdChk("R2", 4'd0, 64'h02);

    curReq = "R9";
    drive(1, 0, 4'd1, 0, 0, 0);
    drive(1, 0, 4'd1, 0, 0, 0);
    a = regRdData;
    drive(0, 0, 0, 0, 0, 0);
    b = regRdData;
    hard("R9", b - a, 64'd1);

    curReq = "R4";
    pulse(0, 0); pulse(0, 1); pulse(0, 2); pulse(0, 3); pulse(0, 1);
    pulse(3, 0); pulse(3, 2); pulse(3, 1); pulse(3, 3);
    pulse(1, 2); pulse(1, 0);
    idle(3);
    rdChk("R4", 4'd3, rbW(0, 5));

    curReq = "R3";
    wrCtl(ctlWord(3, 0, 0, 0));
    drive(1, 0, 4'd3, 0, 0, 0);
    drive(1, 0, 4'd3, 0, 0, 0);
    g1 = regRdData;
    drive(1, 0, 4'd3, 0, 0, 0);
    g2 = regRdData;
    drive(0, 0, 0, 0, 0, 0);
    g3 = regRdData;
    hard("R3", g1, rbW(0, 5));
    hard("R3", g2, rbW(0, 5));
    hard("R3", g3, rbW(3, 4));

    curReq = "R5";
    wrCtl(ctlWord(3, 1, 1, 0));
    idle(1);
    pulse(3, 0); pulse(3, 1); pulse(3, 2); pulse(3, 1); pulse(3, 3);
    idle(3);
    rdChk("R5", 4'd3, rbW(3, 2));

    curReq = "R8";
    wrCtl(ctlWord(3, 1, 1, 0));
    idle(3);
    rdChk("R8", 4'd3, rbW(3, 2));
    wrCtl(ctlWord(3, 1, 2, 0));
    pulse(3, 2);
    idle(3);
    rdChk("R8", 4'd3, rbW(3, 0));

    curReq = "R6";
    wrCtl(ctlWord(3, 1, 2, 1));
    idle(1);
    pulse(3, 2); pulse(3, 2); pulse(3, 2);
    idle(3);
    rdChk("R6", 4'd3, rbW(3, 0));
    rdChk("R6", 4'd2, ctlWord(3, 1, 2, 1));
    wrCtl(ctlWord(3, 1, 2, 0));
    pulse(3, 2); pulse(3, 2); pulse(3, 2);
    idle(3);
    rdChk("R6", 4'd3, rbW(3, 3));

    curReq = "R7";
    wrCtl(ctlWord(1, 0, 0, 0));
    idle(1);
    for (int i = 0; i < 300; i++) pulse(1, 2'(i));
    idle(3);
    rdChk("R7", 4'd3, rbW(1, 44));

    curReq = "R10";
    drive(0, 1, 4'd0, '1, 0, 0);
    drive(0, 1, 4'd1, '1, 0, 0);
    drive(0, 1, 4'd3, '1, 0, 0);
    idle(2);
    rdChk("R10", 4'd0, 64'h02);
    rdChk("R10", 4'd2, ctlWord(1, 0, 0, 0));
    rdChk("R10", 4'd3, rbW(1, 44));

    curReq = "R4 R5 R8 random";
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] d;
      logic w;
      w = ($urandom_range(0, 24) == 0);
      d = {$urandom, $urandom};
      if (($urandom & 3) != 0) d[8] = mFilt;
      drive(($urandom & 1) == 1, w, w ? 4'd2 : 4'($urandom_range(0, 5)), d,
            4'($urandom), (4*PORT_W)'($urandom));
    end
    idle(4);

    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule